// File: doc/BRIEF.md
# I2C Start/Stop Condition Sequencer

This block sits between software, a master I2C byte engine and the open-drain SCL and SDA pads. It drives the two pull-low enables and watches the synchronised bus for start and stop conditions. A run-time mode input picks who makes the conditions. In manual mode, software-controlled pull-low bits are combined with the engine's bits and sent straight to the pads, and the block only observes the bus. In automatic mode, single-cycle request pulses for start, repeated start and stop are held as pending bits. The block then plays out the matching pad sequence, timed by a programmable half-period count of system clocks.

The shared condition interrupt changes its meaning with the mode. In manual mode it reports a start or stop that was detected on the bus. In automatic mode it reports only that a requested sequence has finished. A sequence begins only while the byte engine says its 9-clock data and acknowledge phase is idle. When no sequence is running, the engine's own pull-low bits reach the pads.

Top module: `i2c_cond_seq`

## Requirements
- R1: After reset, both pull-low outputs are 0, all three pending bits are 0, and `gen_done`, `start_seen`, `stop_seen` and `cond_irq` are 0.
- R2: With `auto_mode`=0, each pull-low output equals the OR of its software bit and its engine bit, registered one clock later. Request pulses are ignored: no pending bit is set and no `gen_done` occurs.
- R3: A falling SDA while SCL is high gives a one-cycle `start_seen` pulse. The pulse is high on the fourth rising clock edge after a pad-driving input changes, because of the output register, two synchroniser flops and the detection register.
- R4: A rising SDA while SCL is high gives a one-cycle `stop_seen` pulse with the same latency as R3. An SDA change while SCL is low gives neither pulse.
- R5: With `auto_mode`=0, `cond_irq` pulses one cycle after each `start_seen` or `stop_seen` pulse.
- R6: Start sequence: both lines released for H cycles, then SDA pulled low for H cycles while SCL stays released, then SCL pulled low. On the pads, SCL goes low exactly H cycles after SDA goes low.
- R7: Stop sequence: both lines pulled low for H cycles, then SCL released for H cycles with SDA still low, then SDA released. SCL release follows SDA pull-low by H cycles, and SDA release follows SCL release by H cycles.
- R8: Repeated start: SDA released with SCL low for H cycles, SCL released for H cycles, then the start sequence from its SDA pull-low onward. The three intervals between pad changes are each H cycles.
- R9: Each pending bit (`pend_stop`, `pend_rstart`, `pend_start`) is set by its request pulse in automatic mode. It clears on the same edge that raises the one-cycle `gen_done` pulse for its sequence.
- R10: When several requests are pending, they run one after another in the order stop, then repeated start, then start.
- R11: With `auto_mode`=1, `cond_irq` pulses one cycle after `gen_done`, and bus detections do not raise it. `start_seen` and `stop_seen` still report the generated conditions.
- R12: A pending request does not start while `eng_idle` is 0. During that time the pads follow the engine bits. The request runs once `eng_idle` returns to 1.
- R13: A `half_period` value of 0 is treated as 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_mode | input | 1 | 1 = hardware generates conditions, 0 = software drives the pads |
| half_period | input | 16 | Half-period length in system clocks |
| req_start | input | 1 | One-cycle request for a start condition |
| req_rstart | input | 1 | One-cycle request for a repeated start condition |
| req_stop | input | 1 | One-cycle request for a stop condition |
| sw_scl_low | input | 1 | Software pull-low bit for SCL |
| sw_sda_low | input | 1 | Software pull-low bit for SDA |
| eng_scl_low | input | 1 | Byte engine pull-low bit for SCL |
| eng_sda_low | input | 1 | Byte engine pull-low bit for SDA |
| eng_idle | input | 1 | Byte engine is between frames |
| scl_in | input | 1 | SCL pad level |
| sda_in | input | 1 | SDA pad level |
| scl_low | output | 1 | Pull SCL pad low |
| sda_low | output | 1 | Pull SDA pad low |
| pend_start | output | 1 | Start request pending |
| pend_rstart | output | 1 | Repeated start request pending |
| pend_stop | output | 1 | Stop request pending |
| gen_done | output | 1 | One-cycle pulse: a generated sequence has finished |
| start_seen | output | 1 | One-cycle pulse: start condition detected |
| stop_seen | output | 1 | One-cycle pulse: stop condition detected |
| cond_irq | output | 1 | Condition interrupt pulse, source chosen by mode |

## Verification
In automatic mode, the detector and the generator act on the same event. The start or stop the block plays onto the looped-back pads is detected a few cycles around the moment the generator reports completion. Each automatic scenario therefore counts `start_seen`, `stop_seen`, `gen_done` and `cond_irq` pulses over the whole sequence. A correct run shows one detection and one interrupt per sequence, and that interrupt must follow `gen_done` rather than the detection. The manual scenarios make the reverse check: detections raise the interrupt with an exact latency, and request pulses are ignored.

// File: rtl/i2c_cond_seq_pkg.sv
package i2c_cond_seq_pkg;

  // Pending request bit positions; a lower index has lower priority.
  localparam int unsigned PI_START  = 0;
  localparam int unsigned PI_RSTART = 1;
  localparam int unsigned PI_STOP   = 2;
  localparam int unsigned N_REQ     = 3;

  typedef enum logic [2:0] {
    G_IDLE,
    G_RS_SDA,   // SCL low, SDA released
    G_ST_REL,   // both released
    G_ST_SDA,   // SDA low, SCL released
    G_SP_LOW,   // both low
    G_SP_SCL,   // SCL released, SDA low
    G_HOLD      // final levels for one cycle
  } gen_state_t;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '1;
          else     stage_q[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '1;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_seen,
  output logic stop_seen
);

  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p      <= 1'b1;
      sda_p      <= 1'b1;
      start_seen <= 1'b0;
      stop_seen  <= 1'b0;
    end else begin
      scl_p      <= scl_s;
      sda_p      <= sda_s;
      start_seen <= scl_s & scl_p & sda_p & ~sda_s;
      stop_seen  <= scl_s & scl_p & ~sda_p & sda_s;
    end
  end

  // R3
  start_level_chk: assert property (@(posedge clk) disable iff (rst)
    start_seen |-> (!sda_p && scl_p));

  // R4
  det_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_seen, stop_seen}));

endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
  import i2c_cond_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             eng_idle,
  input  logic [N_REQ-1:0] req,
  input  logic [CNT_W-1:0] half_period,
  output logic             scl_drv,
  output logic             sda_drv,
  output logic             busy,
  output logic             done,
  output logic [N_REQ-1:0] pend
);

  gen_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] hp_eff;
  logic [N_REQ-1:0] cur;
  logic [N_REQ-1:0] pend_set;
  logic             tick;

  assign hp_eff   = (half_period == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : half_period;
  assign pend_set = pend | req;
  assign tick     = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= G_IDLE;
      cnt   <= '0;
      pend  <= '0;
      cur   <= '0;
      done  <= 1'b0;
    end else if (!enable) begin
      state <= G_IDLE;
      cnt   <= '0;
      pend  <= '0;
      cur   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      pend <= pend_set;
      unique case (state)
        G_IDLE: begin
          if (eng_idle && (pend != '0)) begin
            cnt <= hp_eff - 1'b1;
            if (pend[PI_STOP]) begin
              state <= G_SP_LOW;
              cur   <= N_REQ'(1) << PI_STOP;
            end else if (pend[PI_RSTART]) begin
              state <= G_RS_SDA;
              cur   <= N_REQ'(1) << PI_RSTART;
            end else begin
              state <= G_ST_REL;
              cur   <= N_REQ'(1) << PI_START;
            end
          end
        end
        G_RS_SDA: begin
          if (tick) begin
            state <= G_ST_REL;
            cnt   <= hp_eff - 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        G_ST_REL: begin
          if (tick) begin
            state <= G_ST_SDA;
            cnt   <= hp_eff - 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        G_ST_SDA, G_SP_SCL: begin
          if (tick) begin
            state <= G_HOLD;
            done  <= 1'b1;
            pend  <= pend_set & ~cur;
          end else cnt <= cnt - 1'b1;
        end
        G_SP_LOW: begin
          if (tick) begin
            state <= G_SP_SCL;
            cnt   <= hp_eff - 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        G_HOLD: state <= G_IDLE;
        default: state <= G_IDLE;
      endcase
    end
  end

  always_comb begin
    scl_drv = 1'b0;
    sda_drv = 1'b0;
    unique case (state)
      G_RS_SDA: scl_drv = 1'b1;
      G_ST_SDA: sda_drv = 1'b1;
      G_SP_LOW: begin scl_drv = 1'b1; sda_drv = 1'b1; end
      G_SP_SCL: sda_drv = 1'b1;
      G_HOLD: begin
        scl_drv = ~cur[PI_STOP];
        sda_drv = ~cur[PI_STOP];
      end
      default: ;
    endcase
  end

  assign busy = (state != G_IDLE);

  // R10
  stop_first_chk: assert property (@(posedge clk) disable iff (rst || !enable)
    (state == G_IDLE && eng_idle && pend[PI_STOP]) |=> (state == G_SP_LOW));

  // R9
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (($past(pend) & ~pend) != '0));

  // R8
  hold_once_chk: assert property (@(posedge clk) disable iff (rst || !enable)
    (state == G_HOLD) |=> (state == G_IDLE));

  // R12
  engine_wait_chk: assert property (@(posedge clk) disable iff (rst || !enable)
    (state == G_IDLE && !eng_idle) |=> (state == G_IDLE));

endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
  import i2c_cond_seq_pkg::*;
#(
  parameter int unsigned HP_W = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            auto_mode,
  input  logic [HP_W-1:0] half_period,
  input  logic            req_start,
  input  logic            req_rstart,
  input  logic            req_stop,
  input  logic            sw_scl_low,
  input  logic            sw_sda_low,
  input  logic            eng_scl_low,
  input  logic            eng_sda_low,
  input  logic            eng_idle,
  input  logic            scl_in,
  input  logic            sda_in,
  output logic            scl_low,
  output logic            sda_low,
  output logic            pend_start,
  output logic            pend_rstart,
  output logic            pend_stop,
  output logic            gen_done,
  output logic            start_seen,
  output logic            stop_seen,
  output logic            cond_irq
);

  logic [1:0]       bus_s;
  logic             gen_scl, gen_sda, gen_busy;
  logic [N_REQ-1:0] req_vec, pend_vec;

  i2c_bus_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({scl_in, sda_in}),
    .dout (bus_s)
  );

  i2c_cond_detect u_det (
    .clk        (clk),
    .rst        (rst),
    .scl_s      (bus_s[1]),
    .sda_s      (bus_s[0]),
    .start_seen (start_seen),
    .stop_seen  (stop_seen)
  );

  always_comb begin
    req_vec            = '0;
    req_vec[PI_START]  = req_start;
    req_vec[PI_RSTART] = req_rstart;
    req_vec[PI_STOP]   = req_stop;
  end

  i2c_cond_gen #(.CNT_W(HP_W)) u_gen (
    .clk         (clk),
    .rst         (rst),
    .enable      (auto_mode),
    .eng_idle    (eng_idle),
    .req         (req_vec),
    .half_period (half_period),
    .scl_drv     (gen_scl),
    .sda_drv     (gen_sda),
    .busy        (gen_busy),
    .done        (gen_done),
    .pend        (pend_vec)
  );

  assign pend_start  = pend_vec[PI_START];
  assign pend_rstart = pend_vec[PI_RSTART];
  assign pend_stop   = pend_vec[PI_STOP];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_low  <= 1'b0;
      sda_low  <= 1'b0;
      cond_irq <= 1'b0;
    end else begin
      if (auto_mode && gen_busy) begin
        scl_low <= gen_scl;
        sda_low <= gen_sda;
      end else if (auto_mode) begin
        scl_low <= eng_scl_low;
        sda_low <= eng_sda_low;
      end else begin
        scl_low <= sw_scl_low | eng_scl_low;
        sda_low <= sw_sda_low | eng_sda_low;
      end
      cond_irq <= auto_mode ? gen_done : (start_seen | stop_seen);
    end
  end

  // R11
  auto_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_mode && gen_done) |=> cond_irq);

  // R2
  manual_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !auto_mode |=> !gen_busy);

  // R5
  manual_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (!auto_mode && (start_seen || stop_seen)) |=> cond_irq);

endmodule

// File: tb/test_i2c_cond_seq.sv
`timescale 1ns/1ps
module test_i2c_cond_seq;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic auto_mode = 1'b0;
  logic [15:0] half_period = 16'd4;
  logic req_start = 1'b0, req_rstart = 1'b0, req_stop = 1'b0;
  logic sw_scl_low = 1'b0, sw_sda_low = 1'b0;
  logic eng_scl_low = 1'b0, eng_sda_low = 1'b0, eng_idle = 1'b1;
  logic scl_in, sda_in;
  logic scl_low, sda_low, pend_start, pend_rstart, pend_stop;
  logic gen_done, start_seen, stop_seen, cond_irq;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  int n_irq = 0, n_start = 0, n_stop = 0, n_done = 0;
  int t_scl_fall = 0, t_scl_rise = 0, t_sda_fall = 0, t_sda_rise = 0;
  logic prev_scl = 1'b0, prev_sda = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // open-drain loopback with pull-ups
  assign scl_in = ~scl_low;
  assign sda_in = ~sda_low;

  i2c_cond_seq i_i2c_cond_seq (
    .clk(clk), .rst(rst), .auto_mode(auto_mode), .half_period(half_period),
    .req_start(req_start), .req_rstart(req_rstart), .req_stop(req_stop),
    .sw_scl_low(sw_scl_low), .sw_sda_low(sw_sda_low),
    .eng_scl_low(eng_scl_low), .eng_sda_low(eng_sda_low), .eng_idle(eng_idle),
    .scl_in(scl_in), .sda_in(sda_in), .scl_low(scl_low), .sda_low(sda_low),
    .pend_start(pend_start), .pend_rstart(pend_rstart), .pend_stop(pend_stop),
    .gen_done(gen_done), .start_seen(start_seen), .stop_seen(stop_seen),
    .cond_irq(cond_irq)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (cond_irq)   n_irq++;
      if (start_seen) n_start++;
      if (stop_seen)  n_stop++;
      if (gen_done)   n_done++;
      if (scl_low && !prev_scl) t_scl_fall = cyc;
      if (!scl_low && prev_scl) t_scl_rise = cyc;
      if (sda_low && !prev_sda) t_sda_fall = cyc;
      if (!sda_low && prev_sda) t_sda_rise = cyc;
    end
    prev_scl = scl_low;
    prev_sda = sda_low;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_done(input string tag);
    bit seen = 0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(negedge clk);
      if (gen_done) seen = 1;
    end
    check(seen, {tag, " done timeout"}, 0, 1);
  endtask

  task automatic pulse_req(input bit s, input bit r, input bit p);
    req_start = s; req_rstart = r; req_stop = p;
    @(negedge clk);
    req_start = 0; req_rstart = 0; req_stop = 0;
  endtask

  task automatic t_reset();
    // R1
    check(!scl_low && !sda_low, "R1 pads", {scl_low, sda_low}, 0);
    check({pend_stop, pend_rstart, pend_start} == 3'b000, "R1 pend",
          {pend_stop, pend_rstart, pend_start}, 0);
    check(!gen_done && !start_seen && !stop_seen && !cond_irq, "R1 pulses",
          {gen_done, start_seen, stop_seen, cond_irq}, 0);
  endtask

  task automatic t_manual_drive();
    int d0;
    auto_mode = 0;
    sw_scl_low = 1; @(negedge clk);
    check(scl_low && !sda_low, "R2 sw scl", {scl_low, sda_low}, 2);
    sw_scl_low = 0; eng_sda_low = 1; @(negedge clk);
    check(!scl_low && sda_low, "R2 eng sda", {scl_low, sda_low}, 1);
    eng_sda_low = 0; @(negedge clk);
    check(!scl_low && !sda_low, "R2 release", {scl_low, sda_low}, 0);
    idle_cycles(8);
    d0 = n_done;
    pulse_req(1, 1, 1);
    idle_cycles(20);
    check({pend_stop, pend_rstart, pend_start} == 3'b000, "R2 req ignored pend",
          {pend_stop, pend_rstart, pend_start}, 0);
    check(n_done == d0 && !scl_low && !sda_low, "R2 req ignored bus", n_done - d0, 0);
  endtask

  task automatic t_detect();
    int i0, p0, s0;
    auto_mode = 0; sw_scl_low = 0; sw_sda_low = 0;
    idle_cycles(8);
    i0 = n_irq; p0 = n_stop;
    sw_sda_low = 1;                       // SDA falls with SCL high
    idle_cycles(3);
    check(!start_seen, "R3 early", start_seen, 0);
    @(negedge clk);
    check(start_seen, "R3 start latency", start_seen, 1);
    @(negedge clk);
    check(cond_irq && !start_seen, "R5 irq after start", cond_irq, 1);
    sw_scl_low = 1; idle_cycles(6);
    sw_sda_low = 0; idle_cycles(6);       // SDA rises with SCL low
    check(n_stop == p0, "R4 no stop while scl low", n_stop - p0, 0);
    sw_sda_low = 1; idle_cycles(6);
    s0 = n_start;
    sw_scl_low = 0; idle_cycles(6);
    check(n_start == s0, "R4 no start on scl rise", n_start - s0, 0);
    sw_sda_low = 0;                       // SDA rises with SCL high
    idle_cycles(3);
    check(!stop_seen, "R4 early", stop_seen, 0);
    @(negedge clk);
    check(stop_seen, "R4 stop latency", stop_seen, 1);
    @(negedge clk);
    check(cond_irq, "R5 irq after stop", cond_irq, 1);
    idle_cycles(4);
    check(n_irq - i0 == 2, "R5 irq count", n_irq - i0, 2);
  endtask

  task automatic t_start(input int h, input int exp_gap, input string tag);
    int i0, s0, d0;
    auto_mode = 1; half_period = 16'(h);
    eng_scl_low = 0; eng_sda_low = 0; eng_idle = 1;
    idle_cycles(8);
    i0 = n_irq; s0 = n_start; d0 = n_done;
    pulse_req(1, 0, 0);
    check(pend_start, {tag, " pending set"}, pend_start, 1);
    wait_done(tag);
    // R9
    check(!pend_start, "R9 start bit cleared with done", pend_start, 0);
    eng_scl_low = 1; eng_sda_low = 1;
    idle_cycles(10);
    check(t_scl_fall - t_sda_fall == exp_gap, {tag, " sda-to-scl gap"},
          t_scl_fall - t_sda_fall, exp_gap);
    // R11
    check(n_start - s0 == 1, "R11 own start detected", n_start - s0, 1);
    check(n_irq - i0 == 1 && n_done - d0 == 1, "R11 irq once per done", n_irq - i0, 1);
  endtask

  task automatic t_stop(input int h);
    int p0, i0;
    auto_mode = 1; half_period = 16'(h);
    eng_scl_low = 1; eng_sda_low = 0; eng_idle = 1;
    idle_cycles(8);
    p0 = n_stop; i0 = n_irq;
    pulse_req(0, 0, 1);
    wait_done("R7");
    check(!pend_stop, "R9 stop bit cleared with done", pend_stop, 0);
    idle_cycles(10);
    check(t_scl_rise - t_sda_fall == h, "R7 sda low to scl release",
          t_scl_rise - t_sda_fall, h);
    check(t_sda_rise - t_scl_rise == h, "R7 scl release to sda release",
          t_sda_rise - t_scl_rise, h);
    check(n_stop - p0 == 1, "R7 stop on bus", n_stop - p0, 1);
    check(n_irq - i0 == 1, "R11 irq on stop done", n_irq - i0, 1);
  endtask

  task automatic t_rstart(input int h);
    auto_mode = 1; half_period = 16'(h);
    eng_scl_low = 1; eng_sda_low = 1; eng_idle = 1;
    idle_cycles(8);
    pulse_req(0, 1, 0);
    wait_done("R8");
    check(!pend_rstart, "R9 rstart bit cleared with done", pend_rstart, 0);
    idle_cycles(10);
    check(t_scl_rise - t_sda_rise == h, "R8 sda release to scl release",
          t_scl_rise - t_sda_rise, h);
    check(t_sda_fall - t_scl_rise == h, "R8 scl release to sda low",
          t_sda_fall - t_scl_rise, h);
    check(t_scl_fall - t_sda_fall == h, "R8 sda low to scl low",
          t_scl_fall - t_sda_fall, h);
  endtask

  task automatic t_stall();
    int d0;
    auto_mode = 1; half_period = 16'd3;
    eng_scl_low = 1; eng_sda_low = 1; eng_idle = 0;
    idle_cycles(4);
    d0 = n_done;
    pulse_req(1, 0, 0);
    idle_cycles(20);
    check(pend_start && n_done == d0, "R12 held while engine busy", n_done - d0, 0);
    check(scl_low && sda_low, "R12 pads follow engine", {scl_low, sda_low}, 3);
    eng_idle = 1;
    wait_done("R12");
    check(!pend_start, "R12 runs after idle", pend_start, 0);
    idle_cycles(6);
  endtask

  task automatic t_priority();
    auto_mode = 1; half_period = 16'd2;
    eng_scl_low = 1; eng_sda_low = 0; eng_idle = 1;
    idle_cycles(6);
    pulse_req(1, 1, 1);
    wait_done("R10 first");
    check({pend_stop, pend_rstart, pend_start} == 3'b011, "R10 stop first",
          {pend_stop, pend_rstart, pend_start}, 3);
    wait_done("R10 second");
    check({pend_stop, pend_rstart, pend_start} == 3'b001, "R10 rstart second",
          {pend_stop, pend_rstart, pend_start}, 1);
    wait_done("R10 third");
    check({pend_stop, pend_rstart, pend_start} == 3'b000, "R10 start last",
          {pend_stop, pend_rstart, pend_start}, 0);
    idle_cycles(6);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle_cycles(4);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_manual_drive();
    t_detect();
    t_start(5, 5, "R6");
    t_start(0, 1, "R13");
    t_stop(4);
    t_rstart(3);
    t_stall();
    t_priority();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule